// File: doc/BRIEF.md
# Transfer and Call Register Update

This block performs the register bookkeeping that follows a successful operand fetch for a control transfer. When its commit strobe is high for one cycle, it takes the instruction's class flags, the opcode, the ring numbers, the segment numbers and the addresses, and produces the new procedure pointer: ring, segment, instruction counter and privileged bit. In the same cycle it writes one entry of an eight-entry pointer register file.

Transfer-and-set instructions save a return pointer to a register chosen from the opcode. Calls build a stack pointer in register 7. Its segment number is either copied from register 6 or formed from a stack base and the target ring. A plain operand read changes nothing.

The procedure pointer outputs are strobes with data, valid during the commit cycle. The pointer file updates at the clock edge that ends that cycle. Any entry of the file can be read back combinationally through a read index.

Top module: `branch_ptr_commit`

## Requirements
- R1: After reset every pointer file entry reads zero in segment, ring, word and bit fields.
- R2: A commit with neither the transfer nor the call flag raises no strobe and leaves the pointer file unchanged. The same holds when the commit strobe is low.
- R3: For a transfer-and-set, the target entry index is opcode bits [1:0] when the 9-bit opcode is at most octal 273. Otherwise it is opcode bits [1:0] plus 4.
- R4: A transfer-and-set writes ring := current ring, word := (instruction counter + 1) modulo 2^18, and bit := 0 into the target entry.
- R5: A transfer-and-set writes the current segment into the entry's segment field only when the segmented-mode input is 1. Otherwise that field keeps its old value.
- R6: Any transfer or call raises the procedure pointer strobe, with segment := target segment and counter := word address. The ring strobe stays low for a plain transfer.
- R7: The privileged bit output equals the descriptor privilege input when the effective ring is 0, and is 0 otherwise.
- R8: On a call, entry 7's segment is entry 6's segment when the effective ring equals the current ring. Otherwise it is {stack base[11:0], effective ring[2:0]}.
- R9: On a call, entry 7 gets ring := effective ring, word := 0 and bit := 0. The call flag takes priority over the transfer flags.
- R10: On a call, the ring strobe is raised with ring := effective ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| commit | input | 1 | one-cycle update strobe |
| opcode | input | 9 | instruction opcode |
| is_xfer | input | 1 | transfer instruction |
| is_save | input | 1 | transfer-and-set variant |
| is_call | input | 1 | call instruction |
| seg_mode | input | 1 | segmented addressing mode |
| eff_ring | input | 3 | effective (target) ring |
| cur_ring | input | 3 | current procedure ring |
| cur_seg | input | 15 | current procedure segment |
| tgt_seg | input | 15 | target segment |
| word_addr | input | 18 | target word address |
| ic | input | 18 | current instruction counter |
| stack_base | input | 12 | stack segment base |
| desc_priv | input | 1 | privilege bit from the descriptor |
| pr_we | output | 1 | pointer entry write strobe |
| pr_idx | output | 3 | pointer entry index |
| pr_seg_we | output | 1 | pointer segment field write |
| pr_seg | output | 15 | pointer segment data |
| pr_ring | output | 3 | pointer ring data |
| pr_word | output | 18 | pointer word data |
| pr_bit | output | 6 | pointer bit data |
| pp_we | output | 1 | procedure pointer load strobe |
| pp_ring_we | output | 1 | procedure ring load strobe |
| pp_ring | output | 3 | new procedure ring |
| pp_seg | output | 15 | new procedure segment |
| pp_ic | output | 18 | new instruction counter |
| pp_priv | output | 1 | new privileged bit |
| rd_idx | input | 3 | pointer file read index |
| rd_seg | output | 15 | read segment |
| rd_ring | output | 3 | read ring |
| rd_word | output | 18 | read word |
| rd_bit | output | 6 | read bit number |

## Verification
Two functions can meet across adjacent commits: a transfer-and-set that writes entry 6, and a call whose stack segment copies entry 6. The bench provokes this by issuing the save and then, in the next cycle, a call with equal rings. It expects the call's segment output to carry the value just saved, not the stale one. A second overlap sits in a single cycle: a transfer-and-set updates both the pointer entry and the procedure pointer, and the bench judges both outputs within that same commit.

// File: rtl/branch_ptr_commit.sv
module branch_ptr_commit #(
  parameter int OP_W    = 9,
  parameter int SEG_W   = 15,
  parameter int RING_W  = 3,
  parameter int WORD_W  = 18,
  parameter int BIT_W   = 6,
  parameter int NPR     = 8,
  parameter logic [8:0] OP_SPLIT = 9'o273,
  localparam int IDX_W  = $clog2(NPR),
  localparam int BASE_W = SEG_W - RING_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [OP_W-1:0]   opcode,
  input  logic              is_xfer,
  input  logic              is_save,
  input  logic              is_call,
  input  logic              seg_mode,
  input  logic [RING_W-1:0] eff_ring,
  input  logic [RING_W-1:0] cur_ring,
  input  logic [SEG_W-1:0]  cur_seg,
  input  logic [SEG_W-1:0]  tgt_seg,
  input  logic [WORD_W-1:0] word_addr,
  input  logic [WORD_W-1:0] ic,
  input  logic [BASE_W-1:0] stack_base,
  input  logic              desc_priv,
  output logic              pr_we,
  output logic [IDX_W-1:0]  pr_idx,
  output logic              pr_seg_we,
  output logic [SEG_W-1:0]  pr_seg,
  output logic [RING_W-1:0] pr_ring,
  output logic [WORD_W-1:0] pr_word,
  output logic [BIT_W-1:0]  pr_bit,
  output logic              pp_we,
  output logic              pp_ring_we,
  output logic [RING_W-1:0] pp_ring,
  output logic [SEG_W-1:0]  pp_seg,
  output logic [WORD_W-1:0] pp_ic,
  output logic              pp_priv,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [SEG_W-1:0]  rd_seg,
  output logic [RING_W-1:0] rd_ring,
  output logic [WORD_W-1:0] rd_word,
  output logic [BIT_W-1:0]  rd_bit
);

  logic [SEG_W-1:0]  seg_q  [NPR];
  logic [RING_W-1:0] ring_q [NPR];
  logic [WORD_W-1:0] word_q [NPR];
  logic [BIT_W-1:0]  bit_q  [NPR];

  wire do_call = commit && is_call;
  wire do_save = commit && is_xfer && is_save && !is_call;
  wire do_xfer = commit && (is_xfer || is_call);

  wire [IDX_W-1:0] save_idx = (opcode <= OP_SPLIT) ? IDX_W'(opcode[1:0])
                                                   : IDX_W'(opcode[1:0]) + IDX_W'(4);
  wire [SEG_W-1:0] stk_seg = (eff_ring == cur_ring) ? seg_q[NPR-2]
                                                     : {stack_base, eff_ring};

  assign pr_we     = do_call || do_save;
  assign pr_idx    = do_call ? IDX_W'(NPR-1) : save_idx;
  assign pr_seg_we = do_call || (do_save && seg_mode);
  assign pr_seg    = do_call ? stk_seg : cur_seg;
  assign pr_ring   = do_call ? eff_ring : cur_ring;
  assign pr_word   = do_call ? '0 : ic + WORD_W'(1);
  assign pr_bit    = '0;

  assign pp_we      = do_xfer;
  assign pp_ring_we = do_call;
  assign pp_ring    = eff_ring;
  assign pp_seg     = tgt_seg;
  assign pp_ic      = word_addr;
  assign pp_priv    = (eff_ring == '0) ? desc_priv : 1'b0;

  assign rd_seg  = seg_q[rd_idx];
  assign rd_ring = ring_q[rd_idx];
  assign rd_word = word_q[rd_idx];
  assign rd_bit  = bit_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NPR; k++) begin
        seg_q[k]  <= '0;
        ring_q[k] <= '0;
        word_q[k] <= '0;
        bit_q[k]  <= '0;
      end
    end else if (pr_we) begin
      if (pr_seg_we) seg_q[pr_idx] <= pr_seg;
      ring_q[pr_idx] <= pr_ring;
      word_q[pr_idx] <= pr_word;
      bit_q[pr_idx]  <= pr_bit;
    end
  end

  a_r2_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit || (!is_xfer && !is_call)) |-> (!pr_we && !pp_we && !pp_ring_we));

  a_r3_low_index: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_we && !is_call && opcode <= OP_SPLIT) |-> (pr_idx < IDX_W'(4)));

  a_r7_priv_outer: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_we && eff_ring != '0) |-> !pp_priv);

  a_r9_stack_word: assert property (@(posedge clk) disable iff (!rst_n)
    do_call |=> (word_q[NPR-1] == '0 && bit_q[NPR-1] == '0));

  a_r10_call_ring: assert property (@(posedge clk) disable iff (!rst_n)
    do_call |=> (ring_q[NPR-1] == $past(eff_ring)));

endmodule

// File: tb/branch_ptr_commit_bench.sv
module branch_ptr_commit_bench;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic commit = 0, is_xfer = 0, is_save = 0, is_call = 0, seg_mode = 0, desc_priv = 0;
  logic [8:0]  opcode = 0;
  logic [2:0]  eff_ring = 0, cur_ring = 0, rd_idx = 0;
  logic [14:0] cur_seg = 0, tgt_seg = 0;
  logic [17:0] word_addr = 0, ic = 0;
  logic [11:0] stack_base = 0;
  logic pr_we, pr_seg_we, pp_we, pp_ring_we, pp_priv;
  logic [2:0] pr_idx, pr_ring, pp_ring, rd_ring;
  logic [14:0] pr_seg, pp_seg, rd_seg;
  logic [17:0] pr_word, pp_ic, rd_word;
  logic [5:0] pr_bit, rd_bit;

  branch_ptr_commit u_branch_ptr_commit (.*);

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic eq(input string tag, input longint act, input longint exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic go_save(input logic [8:0] op, input logic [14:0] cs, input logic [17:0] icv,
                         input logic [2:0] cr, input logic sm);
    @(negedge clk);
    commit = 1; is_xfer = 1; is_save = 1; is_call = 0;
    opcode = op; cur_seg = cs; ic = icv; cur_ring = cr; seg_mode = sm;
    #1;
  endtask

  task automatic idle;
    @(negedge clk);
    commit = 0; is_xfer = 0; is_save = 0; is_call = 0;
  endtask

  task automatic rd(input logic [2:0] i);
    rd_idx = i; #1;
  endtask

  task automatic t_reset;
    for (int k = 0; k < 8; k++) begin
      rd(k[2:0]);
      eq("R1 reset", {rd_seg, rd_ring, rd_word, rd_bit}, 0);
    end
  endtask

  task automatic t_index;
    go_save(9'o270, 15'h0011, 18'd9, 3'd2, 1); eq("R3 idx 270", pr_idx, 0);
    idle;
    go_save(9'o273, 15'h1234, 18'h3FFFF, 3'd5, 1); eq("R3 idx 273", pr_idx, 3);
    eq("R6 save pp_we", pp_we, 1); eq("R6 no ring we", pp_ring_we, 0);
    idle; rd(3);
    eq("R4 ring", rd_ring, 5); eq("R4 word wrap", rd_word, 0); eq("R5 seg mode", rd_seg, 15'h1234);
    go_save(9'o274, 15'h0001, 18'd1, 3'd1, 1); eq("R3 idx 274", pr_idx, 4);
    idle;
    go_save(9'o277, 15'h0002, 18'd5, 3'd4, 1); eq("R3 idx 277", pr_idx, 7);
    idle; rd(7); eq("R4 word ic+1", rd_word, 6); eq("R4 bit", rd_bit, 0);
  endtask

  task automatic t_absmode;
    go_save(9'o273, 15'h0555, 18'd20, 3'd6, 0);
    idle; rd(3);
    eq("R5 seg kept", rd_seg, 15'h1234); eq("R4 ring abs", rd_ring, 6); eq("R4 word abs", rd_word, 21);
  endtask

  task automatic t_plain;
    @(negedge clk);
    commit = 1; is_xfer = 0; is_call = 0; is_save = 1; opcode = 9'o271;
    ic = 18'd77; cur_ring = 3'd7; #1;
    eq("R2 no pr_we", pr_we, 0); eq("R2 no pp_we", pp_we, 0);
    idle; rd(1); eq("R2 entry1 untouched", {rd_seg, rd_ring, rd_word}, 0);
    @(negedge clk);
    is_xfer = 1; is_save = 1; opcode = 9'o271; #1;
    eq("R2 commit low", pr_we | pp_we, 0);
    idle; rd(1); eq("R2 entry1 still zero", rd_word, 0);
  endtask

  task automatic t_xfer_priv;
    @(negedge clk);
    commit = 1; is_xfer = 1; is_save = 0; tgt_seg = 15'h7001; word_addr = 18'h2ABCD;
    eff_ring = 0; desc_priv = 1; #1;
    eq("R6 pp_seg", pp_seg, 15'h7001); eq("R6 pp_ic", pp_ic, 18'h2ABCD);
    eq("R6 no pr write", pr_we, 0); eq("R7 ring0 priv", pp_priv, 1);
    eff_ring = 1; #1; eq("R7 ring1 priv clear", pp_priv, 0);
    eff_ring = 0; desc_priv = 0; #1; eq("R7 ring0 priv zero", pp_priv, 0);
    idle;
  endtask

  task automatic t_call;
    go_save(9'o276, 15'h2AAA, 18'd3, 3'd3, 1); eq("R3 idx 276", pr_idx, 6);
    @(negedge clk);
    is_save = 0; is_call = 1; is_xfer = 0; eff_ring = 3; cur_ring = 3;
    stack_base = 12'hABC; tgt_seg = 15'h0042; word_addr = 18'd100; #1;
    eq("R8 copy entry6", pr_seg, 15'h2AAA); eq("R9 idx 7", pr_idx, 7);
    eq("R10 ring we", pp_ring_we, 1); eq("R10 ring", pp_ring, 3);
    @(negedge clk);
    is_xfer = 1; is_save = 1; opcode = 9'o270; eff_ring = 5; cur_ring = 2; #1;
    eq("R8 stack seg", pr_seg, 15'h55E5); eq("R9 call priority idx", pr_idx, 7);
    eq("R6 call pp_ic", pp_ic, 18'd100);
    idle; rd(7);
    eq("R9 ring", rd_ring, 5); eq("R9 word", rd_word, 0); eq("R9 bit", rd_bit, 0);
    eq("R8 stored seg", rd_seg, 15'h55E5);
    rd(0); eq("R9 entry0 untouched", rd_word, 10);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset; t_index; t_absmode; t_plain; t_xfer_priv; t_call;
      end
      begin
        repeat (5000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule